// File: doc/BRIEF.md
# Compact Integer Execute Unit

This block executes a small subset of a 32-register, 32-bit integer instruction set. Each instruction is presented as a first 16-bit word. Long forms also carry a second 16-bit word that holds a 16-bit immediate or an extension code. The instruction words arrive with a valid strobe. The block holds the general register file and a 4-bit condition flag register. Most operations complete at the clock edge that accepts them.

A signed halfword multiply takes two edges. During the second edge, `busy` is high and the unit accepts no instruction. Opcodes that the unit does not recognise raise `illegal` in the cycle they are presented and change nothing. A combinational peek port reads any register. This port lets the surrounding logic observe the architectural state.

The first word is split into three fields:
- bits 15:11 select the destination or second source register (the "dst" field);
- bits 10:5 hold the opcode;
- bits 4:0 hold the first source register or a 5-bit immediate (the "src" field).

Top module: `cxu_core`

## Requirements
- R1: With opcode 000000 and a nonzero word, register dst gets register src. With opcode 010000, dst gets the 5-bit src field sign-extended to 32 bits.
- R2: Opcode 110001 writes dst with register src plus the second word sign-extended. Opcode 110010 writes dst with register src plus the second word placed in bits 31:16.
- R3: The three move forms, the load-high form, the multiply forms and NOP leave `flags_o` unchanged.
- R4: The multiply forms write dst with the signed 32-bit product of two operands. In every form, each operand is the lower 16 bits of its source. Opcode 000111 uses registers dst and src. Opcode 010111 uses register dst and the sign-extended 5-bit field. Opcode 110111 uses register src and the second word.
- R5: After a multiply is accepted, `busy` is high for exactly one cycle and the product is written at the end of that cycle. An instruction presented while `busy` is high is ignored: it writes nothing and does not raise `illegal`.
- R6: `flags_o` holds CY in bit 3, OV in bit 2, S in bit 1 and Z in bit 0. Opcode 000001 writes dst with NOT of register src. Opcode 001000 writes dst with register dst OR register src. Opcode 110100 writes dst with register src OR the zero-extended second word. These three forms clear OV, set S to result bit 31, set Z when the result is zero, and keep CY.
- R7: Arithmetic shift right writes register dst shifted by a count. Opcode 010101 takes the count from the src field. Opcode 111111 with second word 0x00A0 takes the count from bits 4:0 of register src. CY gets the last bit shifted out, or 0 when the count is 0. OV is cleared, and S and Z follow the result.
- R8: The all-zero first word is a no-operation: no register and no flag changes.
- R9: Register 0 always reads zero, and every write to it is discarded.
- R10: Any other opcode, or opcode 111111 with a second word other than 0x00A0, raises `illegal` while it is presented to an idle unit. Such an instruction changes no register and no flag.
- R11: After reset, all registers and flags are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction words are present |
| insn_hw0 | input | 16 | First instruction word |
| insn_hw1 | input | 16 | Second instruction word (immediate or extension) |
| busy | output | 1 | Multiply in its second cycle; input is ignored |
| illegal | output | 1 | Presented opcode is not recognised |
| flags_o | output | 4 | CY, OV, S, Z (bits 3 down to 0) |
| peek_addr | input | 5 | Register index for the peek port |
| peek_data | output | 32 | Register contents, zero for register 0 |

## Verification
Several rules hold on every cycle, and the bound checker watches them:
- `busy` follows exactly one cycle after an accepted multiply and never lasts two cycles;
- moves, multiplies and illegal words keep the flags;
- the logical forms and the immediate shift clear OV;
- `illegal` only appears on an accepted word;
- register 0 always peeks as zero.

Data values need the bench's reference model and its sweeps:
- multiply products;
- shift results and carries over all 32 counts;
- the S and Z outcomes;
- that a word offered while busy writes nothing.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

   localparam logic [5:0] OP_MOV    = 6'b000000;
   localparam logic [5:0] OP_MOVI5  = 6'b010000;
   localparam logic [5:0] OP_MOVEA  = 6'b110001;
   localparam logic [5:0] OP_MOVHI  = 6'b110010;
   localparam logic [5:0] OP_MULR   = 6'b000111;
   localparam logic [5:0] OP_MULI5  = 6'b010111;
   localparam logic [5:0] OP_MULI16 = 6'b110111;
   localparam logic [5:0] OP_NOT    = 6'b000001;
   localparam logic [5:0] OP_OR     = 6'b001000;
   localparam logic [5:0] OP_ORI    = 6'b110100;
   localparam logic [5:0] OP_SARI   = 6'b010101;
   localparam logic [5:0] OP_EXT    = 6'b111111;
   localparam logic [15:0] EXT_SARR = 16'h00A0;

   typedef enum logic [3:0] {
      K_NOP, K_MOV, K_MOVI5, K_MOVEA, K_MOVHI,
      K_MULR, K_MULI5, K_MULI16,
      K_NOT, K_OR, K_ORI, K_SARR, K_SARI, K_ILL
   } kind_t;

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
   } flags_t;

endpackage

// File: rtl/cxu_decode.sv
module cxu_decode
   import cxu_pkg::*;
(
   input  logic [15:0] hw0,
   input  logic [15:0] hw1,
   output kind_t       kind
);

   always_comb begin
      case (hw0[10:5])
         OP_MOV:    kind = (hw0 == 16'h0000) ? K_NOP : K_MOV;
         OP_MOVI5:  kind = K_MOVI5;
         OP_MOVEA:  kind = K_MOVEA;
         OP_MOVHI:  kind = K_MOVHI;
         OP_MULR:   kind = K_MULR;
         OP_MULI5:  kind = K_MULI5;
         OP_MULI16: kind = K_MULI16;
         OP_NOT:    kind = K_NOT;
         OP_OR:     kind = K_OR;
         OP_ORI:    kind = K_ORI;
         OP_SARI:   kind = K_SARI;
         OP_EXT:    kind = (hw1 == EXT_SARR) ? K_SARR : K_ILL;
         default:   kind = K_ILL;
      endcase
   end

endmodule

// File: rtl/cxu_alu.sv
module cxu_alu
   import cxu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  kind_t            kind,
   input  logic [4:0]       imm5,
   input  logic [15:0]      imm16,
   input  logic [XLEN-1:0]  src1,
   input  logic [XLEN-1:0]  src2,
   input  flags_t           fl_in,
   output logic [XLEN-1:0]  res,
   output logic             wr,
   output flags_t           fl_out
);

   localparam int SHW = $clog2(XLEN);

   logic [SHW-1:0]  cnt;
   logic [XLEN-1:0] sext5, sext16, sar_res;
   logic            sar_cy;

   assign sext5  = {{(XLEN-5){imm5[4]}}, imm5};
   assign sext16 = {{(XLEN-16){imm16[15]}}, imm16};

   always_comb begin
      cnt     = (kind == K_SARR) ? src1[SHW-1:0] : imm5[SHW-1:0];
      sar_res = $signed(src2) >>> cnt;
      sar_cy  = (cnt != '0) && src2[cnt - 1'b1];
   end

   always_comb begin
      res    = '0;
      wr     = 1'b0;
      fl_out = fl_in;
      case (kind)
         K_MOV:   begin res = src1;          wr = 1'b1; end
         K_MOVI5: begin res = sext5;         wr = 1'b1; end
         K_MOVEA: begin res = src1 + sext16; wr = 1'b1; end
         K_MOVHI: begin
            res = src1 + {imm16, {(XLEN-16){1'b0}}};
            wr  = 1'b1;
         end
         K_NOT, K_OR, K_ORI: begin
            if (kind == K_NOT)     res = ~src1;
            else if (kind == K_OR) res = src2 | src1;
            else                   res = src1 | {{(XLEN-16){1'b0}}, imm16};
            wr        = 1'b1;
            fl_out.ov = 1'b0;
            fl_out.s  = res[XLEN-1];
            fl_out.z  = (res == '0);
         end
         K_SARR, K_SARI: begin
            res       = sar_res;
            wr        = 1'b1;
            fl_out.cy = sar_cy;
            fl_out.ov = 1'b0;
            fl_out.s  = sar_res[XLEN-1];
            fl_out.z  = (sar_res == '0);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/cxu_mul.sv
module cxu_mul #(
   parameter int XLEN = 32,
   parameter int OPW  = 16,
   parameter int RAW  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [OPW-1:0]  op_x,
   input  logic [OPW-1:0]  op_y,
   input  logic [RAW-1:0]  dst_in,
   output logic            busy,
   output logic [XLEN-1:0] prod,
   output logic [RAW-1:0]  dst
);

   localparam int PW = 2 * OPW;

   logic [OPW-1:0]        x_q, y_q;
   logic signed [PW-1:0]  p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q  <= '0;
         y_q  <= '0;
         dst  <= '0;
         busy <= 1'b0;
      end else if (busy) begin
         busy <= 1'b0;
      end else if (start) begin
         x_q  <= op_x;
         y_q  <= op_y;
         dst  <= dst_in;
         busy <= 1'b1;
      end
   end

   assign p = $signed(x_q) * $signed(y_q);

   generate
      if (XLEN > PW) begin : g_ext
         assign prod = {{(XLEN-PW){p[PW-1]}}, p};
      end else begin : g_fit
         assign prod = p[XLEN-1:0];
      end
   endgenerate

endmodule

// File: rtl/cxu_regfile.sv
module cxu_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   parameter int NRD  = 3,
   localparam int RAW = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [RAW-1:0]            waddr,
   input  logic [XLEN-1:0]           wdata,
   input  logic [NRD-1:0][RAW-1:0]   raddr,
   output logic [NRD-1:0][XLEN-1:0]  rdata
);

   logic [XLEN-1:0] mem [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (we && (waddr != '0)) begin
         mem[waddr] <= wdata;
      end
   end

   generate
      for (genvar g = 0; g < NRD; g++) begin : g_rd
         assign rdata[g] = (raddr[g] == '0) ? '0 : mem[raddr[g]];
      end
   endgenerate

endmodule

// File: rtl/cxu_core.sv
module cxu_core
   import cxu_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   parameter int MULW = 16,
   localparam int RAW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            insn_valid,
   input  logic [15:0]     insn_hw0,
   input  logic [15:0]     insn_hw1,
   output logic            busy,
   output logic            illegal,
   output logic [3:0]      flags_o,
   input  logic [RAW-1:0]  peek_addr,
   output logic [XLEN-1:0] peek_data
);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("cxu_core: XLEN must be 32");
      end
      if (NREG != 32) begin : g_bad_nreg
         $error("cxu_core: NREG must be 32 for 5-bit register fields");
      end
      if (2 * MULW > XLEN) begin : g_bad_mulw
         $error("cxu_core: product wider than XLEN");
      end
   endgenerate

   kind_t                   kind;
   logic                    accept, mul_start;
   logic [2:0][RAW-1:0]     rd_sel;
   logic [2:0][XLEN-1:0]    rd_val;
   logic [XLEN-1:0]         alu_res, mul_prod, wdata;
   logic                    alu_wr, we;
   logic [RAW-1:0]          mul_dst, waddr;
   logic [MULW-1:0]         mx, my;
   flags_t                  fl_q, fl_nxt;

   cxu_decode u_dec (.hw0(insn_hw0), .hw1(insn_hw1), .kind(kind));

   assign rd_sel = {peek_addr, insn_hw0[15:11], insn_hw0[4:0]};

   cxu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(3)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(rd_sel), .rdata(rd_val)
   );

   assign peek_data = rd_val[2];
   assign accept    = insn_valid & ~busy;
   assign illegal   = accept & (kind == K_ILL);
   assign mul_start = accept & (kind inside {K_MULR, K_MULI5, K_MULI16});

   cxu_alu #(.XLEN(XLEN)) u_alu (
      .kind(kind), .imm5(insn_hw0[4:0]), .imm16(insn_hw1),
      .src1(rd_val[0]), .src2(rd_val[1]), .fl_in(fl_q),
      .res(alu_res), .wr(alu_wr), .fl_out(fl_nxt)
   );

   always_comb begin
      case (kind)
         K_MULI5:  begin mx = rd_val[1][MULW-1:0]; my = {{(MULW-5){insn_hw0[4]}}, insn_hw0[4:0]}; end
         K_MULI16: begin mx = rd_val[0][MULW-1:0]; my = insn_hw1[MULW-1:0]; end
         default:  begin mx = rd_val[1][MULW-1:0]; my = rd_val[0][MULW-1:0]; end
      endcase
   end

   cxu_mul #(.XLEN(XLEN), .OPW(MULW), .RAW(RAW)) u_mul (
      .clk(clk), .rst_n(rst_n), .start(mul_start), .op_x(mx), .op_y(my),
      .dst_in(insn_hw0[15:11]), .busy(busy), .prod(mul_prod), .dst(mul_dst)
   );

   always_comb begin
      if (busy) begin
         we = 1'b1;  waddr = mul_dst;          wdata = mul_prod;
      end else begin
         we = accept & alu_wr;  waddr = insn_hw0[15:11];  wdata = alu_res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fl_q <= '0;
      else if (accept) fl_q <= fl_nxt;
   end

   assign flags_o = fl_q;

endmodule

// File: rtl/cxu_core_chk.sv
module cxu_core_chk #(
   parameter int XLEN = 32,
   parameter int RAW  = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            insn_valid,
   input logic [5:0]      op,
   input logic            busy,
   input logic            illegal,
   input logic [3:0]      flags_o,
   input logic [RAW-1:0]  peek_addr,
   input logic [XLEN-1:0] peek_data
);

   logic acc, is_mul, is_mov, is_clr_ov;
   assign acc       = insn_valid & ~busy;
   assign is_mul    = (op == 6'b000111) || (op == 6'b010111) || (op == 6'b110111);
   assign is_mov    = (op == 6'b000000) || (op == 6'b010000) || (op == 6'b110001) || (op == 6'b110010);
   assign is_clr_ov = (op == 6'b000001) || (op == 6'b001000) || (op == 6'b110100) || (op == 6'b010101);

   AST_MUL_RAISES_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) acc && is_mul |=> busy);                 // R5
   AST_BUSY_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy);                         // R5
   AST_OTHER_NO_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) acc && !is_mul |=> !busy);               // R5
   AST_MUL_KEEPS_FLAGS:  assert property (@(posedge clk) disable iff (!rst_n) (acc && is_mul) || busy |=> $stable(flags_o)); // R4
   AST_MOV_KEEPS_FLAGS:  assert property (@(posedge clk) disable iff (!rst_n) acc && is_mov |=> $stable(flags_o));     // R3
   AST_OV_CLEARED:       assert property (@(posedge clk) disable iff (!rst_n) acc && is_clr_ov |=> !flags_o[2]);       // R6
   AST_ILLEGAL_GATED:    assert property (@(posedge clk) disable iff (!rst_n) illegal |-> acc);                        // R10
   AST_ILLEGAL_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> $stable(flags_o));           // R10
   AST_R0_ZERO:          assert property (@(posedge clk) disable iff (!rst_n) peek_addr == '0 |-> peek_data == '0);    // R9

endmodule

bind cxu_core cxu_core_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
   .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .op(insn_hw0[10:5]),
   .busy(busy), .illegal(illegal), .flags_o(flags_o),
   .peek_addr(peek_addr), .peek_data(peek_data)
);

// File: tb/cxu_core_test.sv
module cxu_core_test;

   localparam logic [5:0] MOV = 6'b000000, MOVI5 = 6'b010000, MOVEA = 6'b110001, MOVHI = 6'b110010;
   localparam logic [5:0] MULR = 6'b000111, MULI5 = 6'b010111, MULI16 = 6'b110111;
   localparam logic [5:0] NOTO = 6'b000001, ORR = 6'b001000, ORI = 6'b110100, SARI = 6'b010101, EXT = 6'b111111;

   logic        clk = 1'b0, rst_n = 1'b0, v = 1'b0;
   logic [15:0] h0 = '0, h1 = '0;
   logic [4:0]  pa = '0;
   wire         busy, illegal;
   wire [3:0]   fl;
   wire [31:0]  pd;

   cxu_core uut (
      .clk(clk), .rst_n(rst_n), .insn_valid(v), .insn_hw0(h0), .insn_hw1(h1),
      .busy(busy), .illegal(illegal), .flags_o(fl), .peek_addr(pa), .peek_data(pd)
   );

   always #5 clk = ~clk;

   int          nchk = 0, nfail = 0;
   logic [31:0] m [32];
   logic [3:0]  mf;   // {cy, ov, s, z}

   function automatic logic [15:0] enc(input logic [4:0] r2, input logic [5:0] op, input logic [4:0] f);
      return {r2, op, f};
   endfunction

   function automatic logic [31:0] smul(input logic [15:0] x, input logic [15:0] y);
      int xi, yi;
      xi = $signed(x);
      yi = $signed(y);
      return 32'(xi * yi);
   endfunction

   function automatic bit known(input logic [5:0] op);
      return op inside {MOV, MOVI5, MOVEA, MOVHI, MULR, MULI5, MULI16, NOTO, ORR, ORI, SARI, EXT};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int r = 0; r < 32; r++) begin
         pa = r[4:0];
         #1;
         chk(tag, pd, m[r]);
      end
   endtask

   task automatic run(input logic [15:0] w0, input logic [15:0] w1, input string tag);
      logic [5:0]  op = w0[10:5];
      logic [4:0]  r2 = w0[15:11];
      logic [4:0]  r1 = w0[4:0];
      logic [31:0] a = m[r1];
      logic [31:0] b = m[r2];
      logic [31:0] res = '0;
      logic [3:0]  nf = mf;
      bit          wr = 0, ill = 0, mul = 0, sar = 0, lg = 0;
      int          cnt = 0;
      case (op)
         MOV:    begin wr = (w0 != 0); res = a; end
         MOVI5:  begin wr = 1; res = {{27{r1[4]}}, r1}; end
         MOVEA:  begin wr = 1; res = a + {{16{w1[15]}}, w1}; end
         MOVHI:  begin wr = 1; res = a + {w1, 16'h0}; end
         MULR:   begin wr = 1; mul = 1; res = smul(b[15:0], a[15:0]); end
         MULI5:  begin wr = 1; mul = 1; res = smul(b[15:0], {{11{r1[4]}}, r1}); end
         MULI16: begin wr = 1; mul = 1; res = smul(a[15:0], w1); end
         NOTO:   begin wr = 1; lg = 1; res = ~a; end
         ORR:    begin wr = 1; lg = 1; res = b | a; end
         ORI:    begin wr = 1; lg = 1; res = a | {16'h0, w1}; end
         SARI:   begin wr = 1; sar = 1; cnt = r1; end
         EXT:    if (w1 == 16'h00A0) begin wr = 1; sar = 1; cnt = a[4:0]; end else ill = 1;
         default: ill = 1;
      endcase
      if (sar) begin
         logic [31:0] t = b;
         nf[3] = 1'b0;
         for (int k = 0; k < cnt; k++) begin
            nf[3] = t[0];
            t = {t[31], t[31:1]};
         end
         res = t;
      end
      if (sar || lg) begin
         nf[2] = 1'b0;
         nf[1] = res[31];
         nf[0] = (res == 0);
      end
      @(negedge clk);
      v = 1'b1; h0 = w0; h1 = w1;
      #1;
      chk({tag, " R10 illegal"}, {31'b0, illegal}, {31'b0, ill});
      @(negedge clk);
      if (mul) begin
         chk("R5 busy high", {31'b0, busy}, 32'd1);
         h0 = enc(r2, MOVI5, 5'd15);
         #1;
         chk("R5 no illegal while busy", {31'b0, illegal}, 32'd0);
         @(negedge clk);
         chk("R5 busy released", {31'b0, busy}, 32'd0);
      end
      v = 1'b0;
      if (wr && r2 != 0) m[r2] = res;
      mf = nf;
      pa = r2;
      #1;
      chk({tag, " result"}, pd, m[r2]);
      chk({tag, " flags"}, {28'b0, fl}, {28'b0, mf});
   endtask

   task automatic load(input logic [4:0] r, input logic [31:0] val);
      logic [15:0] hi = val[31:16] + {15'b0, val[15]};
      run(enc(r, MOVHI, 5'd0), hi, "R2");
      run(enc(r, MOVEA, r), val[15:0], "R2");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL R5 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] init_vals [8];
      init_vals = '{32'h12345678, 32'hFFFF8001, 32'h80000000, 32'h7FFF0003,
                    32'h0000FFFF, 32'hDEADBEEF, 32'h00007FFF, 32'hFFFF0000};
      mf = '0;
      for (int r = 0; r < 32; r++) m[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11 busy", {31'b0, busy}, 32'd0);
      chk("R11 flags", {28'b0, fl}, 32'd0);
      check_all("R11 regs");

      for (int i = 0; i < 8; i++) load(5'(i + 1), init_vals[i]);
      load(5'd15, 32'hFFFFFFFF);

      // R1 / R3: moves keep flags
      for (int i = 0; i < 32; i++) run(enc(5'd9, MOVI5, 5'(i)), 16'h0, "R1 R3 imm5");
      for (int s = 1; s < 9; s++) run(enc(5'd10, MOV, 5'(s)), 16'h0, "R1 R3 reg");

      // R9: writes to register 0 are dropped
      run(enc(5'd0, MOVI5, 5'd7), 16'h0, "R9");
      run(enc(5'd0, MOVEA, 5'd1), 16'h1234, "R9");
      check_all("R9 regs");

      // set CY so R6 can show it is kept
      run(enc(5'd16, MOV, 5'd2), 16'h0, "R1");
      run(enc(5'd16, SARI, 5'd1), 16'h0, "R7 cy set");

      // R6: logical forms
      for (int a = 1; a < 9; a++)
         for (int b = 1; b < 9; b++) begin
            run(enc(5'd11, MOV, 5'(b)), 16'h0, "R1");
            run(enc(5'd11, ORR, 5'(a)), 16'h0, "R6 or");
         end
      for (int a = 0; a < 9; a++) run(enc(5'd12, NOTO, 5'(a)), 16'h0, "R6 not");
      run(enc(5'd12, NOTO, 5'd15), 16'h0, "R6 not zero");
      for (int a = 0; a < 9; a++) run(enc(5'd13, ORI, 5'(a)), 16'(a * 16'h1111 + 16'h8000 * (a % 2)), "R6 ori");
      run(enc(5'd14, MOV, 5'd0), 16'h0, "R1");
      run(enc(5'd14, ORR, 5'd0), 16'h0, "R6 or zero");

      // R7: both shift forms, all counts
      for (int s = 1; s < 7; s++)
         for (int c = 0; c < 32; c++) begin
            run(enc(5'd16, MOV, 5'(s)), 16'h0, "R1");
            run(enc(5'd16, SARI, 5'(c)), 16'h0, "R7 imm");
         end
      for (int c = 0; c < 64; c++) begin
         run(enc(5'd17, MOVEA, 5'd0), 16'(c * 37), "R2");
         run(enc(5'd18, MOV, 5'd6), 16'h0, "R1");
         run(enc(5'd18, EXT, 5'd17), 16'h00A0, "R7 reg");
      end

      // R4 / R5: multiply forms
      for (int a = 1; a < 9; a++)
         for (int b = 1; b < 9; b++) begin
            run(enc(5'd19, MOV, 5'(a)), 16'h0, "R1");
            run(enc(5'd19, MULR, 5'(b)), 16'h0, "R4 R5 reg");
         end
      for (int i = 0; i < 32; i++) begin
         run(enc(5'd20, MOV, 5'd6), 16'h0, "R1");
         run(enc(5'd20, MULI5, 5'(i)), 16'h0, "R4 imm5");
      end
      for (int a = 1; a < 9; a++) run(enc(5'd21, MULI16, 5'(a)), 16'(16'h8000 - a * 16'h0F0F), "R4 imm16");
      run(enc(5'd0, MULR, 5'd1), 16'h0, "R9 mul");
      check_all("R9 R4 regs");

      // R8: no-operation
      run(16'h0000, 16'h0000, "R8");
      check_all("R8 regs");

      // R10: every unknown opcode and a bad extension word
      for (int op = 0; op < 64; op++)
         if (!known(6'(op))) run(enc(5'd22, 6'(op), 5'd3), 16'hFFFF, "R10");
      run(enc(5'd22, EXT, 5'd3), 16'h00A1, "R10 ext");
      check_all("R10 regs");

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule